// File: doc/BRIEF.md
# Hardware Thread Fork Allocator

This block serves the fork operation of a multithreaded processor core whose hardware thread contexts are grouped into virtual processing elements. A fork request names a start address for a new thread and one value to place in that thread's integer register file. The block scans every configured context and takes the lowest-numbered one that is free. A context is free when it belongs to the caller's processing element, is open to dynamic allocation, is not halted and is not already running.

When it finds a context, the block issues one cycle of write strobes toward that context's registers. The restart address goes to the context's restart register, and the operand goes to the chosen integer register. A status word is also written: the context is set running, outside a delay slot, dirty and activated, and it inherits the caller's privilege mode and address-space identifier. When no context is free, the block instead signals a thread fault carrying exception code 1.

The scan is combinational over at most eight contexts. The result is registered, so every accepted request yields exactly one result pulse on the cycle after it is sampled.

Top module: `fork_alloc`

## Requirements
- R1: After reset, `fork_ok` and `fork_fault` are 0, `wr_ctx` is all zeros and `exc_code` is 0.
- R2: Context i qualifies only when its processing-element field (`ctx_vpe` bits [2i+1:2i]) equals `caller_vpe`, `ctx_dyn[i]` is 1, `ctx_halt[i]` is 0 and `ctx_active[i]` is 0.
- R3: Only contexts 0 through `cfg_last` (inclusive) are scanned; a qualifying context above `cfg_last` is never claimed.
- R4: When several contexts qualify, only the lowest-numbered one is claimed, and `wr_ctx` is one-hot with bit i selecting context i.
- R5: On success, `wr_pc` carries `fork_pc`, `wr_gpr_val` carries `fork_val` and `wr_gpr_idx` carries `fork_idx`.
- R6: On success the written status has run-state `wr_runst` = 0 (running), delay-slot flag `wr_dslot` = 0, dirty flag `wr_dirty` = 1 and activated flag `wr_active` = 1.
- R7: On success `wr_ksu` equals `caller_ksu` and `wr_asid` equals `caller_asid`, both sampled with the request.
- R8: When no context qualifies, `fork_fault` pulses with `exc_code` = 1 and `wr_ctx` stays zero.
- R9: A request sampled on a rising edge yields exactly one of `fork_ok` or `fork_fault` for exactly the following cycle; the two are never high together.
- R10: A request sampled while a result pulse is being shown is ignored and produces no pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fork_req | input | 1 | Fork request, sampled on the rising edge |
| fork_pc | input | ADDR_W | Start address for the new thread |
| fork_val | input | DATA_W | Value for the new thread's integer register |
| fork_idx | input | IDX_W | Index of that integer register |
| caller_vpe | input | VPE_W | Processing element of the requesting thread |
| caller_ksu | input | 2 | Privilege mode bits of the requesting thread |
| caller_asid | input | ASID_W | Address-space identifier of the requesting thread |
| cfg_last | input | CNT_W | Highest context number to scan |
| ctx_vpe | input | N_CTX*VPE_W | Processing-element binding of each context |
| ctx_dyn | input | N_CTX | Dynamic-allocation flag of each context |
| ctx_halt | input | N_CTX | Halt flag of each context |
| ctx_active | input | N_CTX | Activated flag of each context |
| fork_ok | output | 1 | One-cycle pulse: a context was claimed |
| fork_fault | output | 1 | One-cycle pulse: no free context |
| exc_code | output | 3 | Thread exception code, 1 during a fault, else 0 |
| wr_ctx | output | N_CTX | One-hot write strobe selecting the claimed context |
| wr_pc | output | ADDR_W | Restart address to write |
| wr_gpr_idx | output | IDX_W | Integer register index to write |
| wr_gpr_val | output | DATA_W | Integer register value to write |
| wr_runst | output | 2 | Run-state field to write |
| wr_dslot | output | 1 | Delay-slot flag to write |
| wr_dirty | output | 1 | Dirty flag to write |
| wr_active | output | 1 | Activated flag to write |
| wr_ksu | output | 2 | Privilege mode bits to write |
| wr_asid | output | ASID_W | Address-space identifier to write |

## Verification
A fault in the qualify or priority logic shows up in the very next cycle as the wrong bit of `wr_ctx`, or as a fault where a success was due. The vector set therefore places the single free context at both ends of the range and just inside and outside `cfg_last`. A wrong busy or pulse register shows within two cycles as a missing, doubled or stretched result pulse. The bench exposes this by holding the request high across three edges. Stale operand or caller registers show in the same pulse cycle as mismatched write data.

// File: rtl/fork_alloc_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the fork allocator.
// Assumes: exception code field is 3 bits wide.
package fork_alloc_pkg;
    typedef enum logic [2:0] {
        EXC_NONE      = 3'd0,
        EXC_FORK_FULL = 3'd1
    } exc_t;

    localparam logic [1:0] RUNST_RUNNING = 2'b00;
endpackage

// File: rtl/fork_scan.sv
`timescale 1ns/1ps
// Module: fork_scan
// Qualifies every context against the caller and picks the lowest-numbered
// free one with a two's-complement priority mask.
// Assumes: N_CTX >= 2; clk and rst_n are used only by the assertions.
module fork_scan #(
    parameter int N_CTX = 8,
    parameter int VPE_W = 2,
    parameter int CNT_W = $clog2(N_CTX)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       cfg_last,
    input  logic [VPE_W-1:0]       caller_vpe,
    input  logic [N_CTX*VPE_W-1:0] ctx_vpe,
    input  logic [N_CTX-1:0]       ctx_dyn,
    input  logic [N_CTX-1:0]       ctx_halt,
    input  logic [N_CTX-1:0]       ctx_active,
    output logic [N_CTX-1:0]       pick,
    output logic                   found
);
    localparam int CMP_W = CNT_W + 1;

    logic [N_CTX-1:0] qual;

    // One qualify term per context: in range, same element, free.
    for (genvar i = 0; i < N_CTX; i++) begin : g_qual
        logic in_range;
        assign in_range = CMP_W'(i) <= {1'b0, cfg_last};
        assign qual[i]  = in_range
                        && (ctx_vpe[i*VPE_W +: VPE_W] == caller_vpe)
                        && ctx_dyn[i] && !ctx_halt[i] && !ctx_active[i];
    end

    // Isolate the lowest set qualify bit.
    always_comb begin
        pick  = qual & (~qual + 1'b1);
        found = |qual;
    end

    AST_PICK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (pick & ~qual) == '0);                                        // R2
    AST_NONE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (((pick - 1'b1) & qual) == '0));                    // R4
    AST_PICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((pick >> cfg_last) <= 1));                         // R3
endmodule

// File: rtl/fork_commit.sv
`timescale 1ns/1ps
// Module: fork_commit
// Registers the scan result for one cycle: write strobes and data on success,
// or a fault pulse with exception code on failure. Requests that arrive while
// a result is shown are dropped.
// Assumes: pick is one-hot whenever found is 1.
module fork_commit
    import fork_alloc_pkg::*;
#(
    parameter int N_CTX  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fork_req,
    input  logic              found,
    input  logic [N_CTX-1:0]  pick,
    input  logic [ADDR_W-1:0] fork_pc,
    input  logic [DATA_W-1:0] fork_val,
    input  logic [IDX_W-1:0]  fork_idx,
    input  logic [1:0]        caller_ksu,
    input  logic [ASID_W-1:0] caller_asid,
    output logic              fork_ok,
    output logic              fork_fault,
    output logic [2:0]        exc_code,
    output logic [N_CTX-1:0]  wr_ctx,
    output logic [ADDR_W-1:0] wr_pc,
    output logic [IDX_W-1:0]  wr_gpr_idx,
    output logic [DATA_W-1:0] wr_gpr_val,
    output logic [1:0]        wr_runst,
    output logic              wr_dslot,
    output logic              wr_dirty,
    output logic              wr_active,
    output logic [1:0]        wr_ksu,
    output logic [ASID_W-1:0] wr_asid
);
    logic busy;
    logic accept;

    // A request is taken only when no result is currently on the outputs.
    always_comb begin
        busy   = fork_ok || fork_fault;
        accept = fork_req && !busy;
    end

    // Result register: one-cycle pulse carrying strobes and write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fork_ok    <= 1'b0;
            fork_fault <= 1'b0;
            exc_code   <= EXC_NONE;
            wr_ctx     <= '0;
            wr_pc      <= '0;
            wr_gpr_idx <= '0;
            wr_gpr_val <= '0;
            wr_ksu     <= '0;
            wr_asid    <= '0;
        end else begin
            fork_ok    <= 1'b0;
            fork_fault <= 1'b0;
            exc_code   <= EXC_NONE;
            wr_ctx     <= '0;
            if (accept && found) begin
                fork_ok    <= 1'b1;
                wr_ctx     <= pick;
                wr_pc      <= fork_pc;
                wr_gpr_idx <= fork_idx;
                wr_gpr_val <= fork_val;
                wr_ksu     <= caller_ksu;
                wr_asid    <= caller_asid;
            end else if (accept) begin
                fork_fault <= 1'b1;
                exc_code   <= EXC_FORK_FULL;
            end
        end
    end

    // Fixed status fields of a freshly started context.
    always_comb begin
        wr_runst  = RUNST_RUNNING;
        wr_dslot  = 1'b0;
        wr_dirty  = fork_ok;
        wr_active = fork_ok;
    end

    AST_ACCEPT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (fork_req && !fork_ok && !fork_fault) |=> (fork_ok || fork_fault)); // R9
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fork_ok && fork_fault));                                     // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fork_ok || fork_fault) |=> !(fork_ok || fork_fault));         // R10
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        fork_fault |-> (exc_code == 3'd1 && wr_ctx == '0));            // R8
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        fork_ok |-> ($countones(wr_ctx) == 1));                        // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fork_ok |-> (wr_ctx == '0 && !wr_active));                    // R6
endmodule

// File: rtl/fork_alloc.sv
`timescale 1ns/1ps
// Module: fork_alloc (top)
// Fork allocator: finds the lowest free hardware context in the caller's
// processing element and issues one cycle of writes to start it, or a
// thread fault when none is free.
// Assumes: context flags are stable in the cycle the request is sampled.
module fork_alloc #(
    parameter int N_CTX  = 8,
    parameter int VPE_W  = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int ASID_W = 8,
    parameter int CNT_W  = $clog2(N_CTX)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fork_req,
    input  logic [ADDR_W-1:0]      fork_pc,
    input  logic [DATA_W-1:0]      fork_val,
    input  logic [IDX_W-1:0]       fork_idx,
    input  logic [VPE_W-1:0]       caller_vpe,
    input  logic [1:0]             caller_ksu,
    input  logic [ASID_W-1:0]      caller_asid,
    input  logic [CNT_W-1:0]       cfg_last,
    input  logic [N_CTX*VPE_W-1:0] ctx_vpe,
    input  logic [N_CTX-1:0]       ctx_dyn,
    input  logic [N_CTX-1:0]       ctx_halt,
    input  logic [N_CTX-1:0]       ctx_active,
    output logic                   fork_ok,
    output logic                   fork_fault,
    output logic [2:0]             exc_code,
    output logic [N_CTX-1:0]       wr_ctx,
    output logic [ADDR_W-1:0]      wr_pc,
    output logic [IDX_W-1:0]       wr_gpr_idx,
    output logic [DATA_W-1:0]      wr_gpr_val,
    output logic [1:0]             wr_runst,
    output logic                   wr_dslot,
    output logic                   wr_dirty,
    output logic                   wr_active,
    output logic [1:0]             wr_ksu,
    output logic [ASID_W-1:0]      wr_asid
);
    logic [N_CTX-1:0] pick;
    logic             found;

    fork_scan #(.N_CTX(N_CTX), .VPE_W(VPE_W), .CNT_W(CNT_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_last   (cfg_last),
        .caller_vpe (caller_vpe),
        .ctx_vpe    (ctx_vpe),
        .ctx_dyn    (ctx_dyn),
        .ctx_halt   (ctx_halt),
        .ctx_active (ctx_active),
        .pick       (pick),
        .found      (found)
    );

    fork_commit #(
        .N_CTX(N_CTX), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .ASID_W(ASID_W)
    ) u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .fork_req    (fork_req),
        .found       (found),
        .pick        (pick),
        .fork_pc     (fork_pc),
        .fork_val    (fork_val),
        .fork_idx    (fork_idx),
        .caller_ksu  (caller_ksu),
        .caller_asid (caller_asid),
        .fork_ok     (fork_ok),
        .fork_fault  (fork_fault),
        .exc_code    (exc_code),
        .wr_ctx      (wr_ctx),
        .wr_pc       (wr_pc),
        .wr_gpr_idx  (wr_gpr_idx),
        .wr_gpr_val  (wr_gpr_val),
        .wr_runst    (wr_runst),
        .wr_dslot    (wr_dslot),
        .wr_dirty    (wr_dirty),
        .wr_active   (wr_active),
        .wr_ksu      (wr_ksu),
        .wr_asid     (wr_asid)
    );
endmodule

// File: tb/fork_alloc_test.sv
`timescale 1ns/1ps
module fork_alloc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fork_req = 1'b0;
    logic [31:0] fork_pc = '0;
    logic [31:0] fork_val = '0;
    logic [4:0]  fork_idx = '0;
    logic [1:0]  caller_vpe = '0;
    logic [1:0]  caller_ksu = '0;
    logic [7:0]  caller_asid = '0;
    logic [2:0]  cfg_last = 3'd7;
    logic [15:0] ctx_vpe = '0;
    logic [7:0]  ctx_dyn = '0;
    logic [7:0]  ctx_halt = '0;
    logic [7:0]  ctx_active = '0;
    logic        fork_ok, fork_fault, wr_dslot, wr_dirty, wr_active;
    logic [2:0]  exc_code;
    logic [7:0]  wr_ctx, wr_asid;
    logic [31:0] wr_pc, wr_gpr_val;
    logic [4:0]  wr_gpr_idx;
    logic [1:0]  wr_runst, wr_ksu;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fork_alloc uut (.*);

    typedef struct packed {
        logic [2:0]  last;
        logic [1:0]  cvpe;
        logic [15:0] cvpes;
        logic [7:0]  dyn;
        logic [7:0]  halt;
        logic [7:0]  act;
        logic [7:0]  exp;   // expected one-hot target, 0 = fault
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd7, 2'd0, 16'h0000, 8'hFF, 8'h00, 8'h00, 8'h01}, // all free
        '{3'd7, 2'd0, 16'h0000, 8'hFF, 8'h00, 8'h01, 8'h02}, // ctx0 active
        '{3'd7, 2'd0, 16'h0000, 8'h20, 8'h00, 8'h00, 8'h20}, // only dyn 5
        '{3'd7, 2'd0, 16'h0000, 8'hFF, 8'h0F, 8'h00, 8'h10}, // low halted
        '{3'd7, 2'd1, 16'h1000, 8'hFF, 8'h00, 8'h00, 8'h40}, // element match 6
        '{3'd3, 2'd0, 16'h0000, 8'h20, 8'h00, 8'h00, 8'h00}, // out of range
        '{3'd5, 2'd0, 16'h0000, 8'h20, 8'h00, 8'h00, 8'h20}, // range edge
        '{3'd7, 2'd0, 16'h0000, 8'hFF, 8'h00, 8'hFF, 8'h00}, // all active
        '{3'd0, 2'd0, 16'h0000, 8'hFF, 8'h00, 8'h00, 8'h01}, // one context
        '{3'd7, 2'd2, 16'hAAAA, 8'h80, 8'h00, 8'h00, 8'h80}  // top context
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load(input vec_t v, input int n);
        cfg_last    = v.last;
        caller_vpe  = v.cvpe;
        ctx_vpe     = v.cvpes;
        ctx_dyn     = v.dyn;
        ctx_halt    = v.halt;
        ctx_active  = v.act;
        fork_pc     = 32'h8000_0000 + 32'(n * 16);
        fork_val    = 32'hC0DE_0000 + 32'(n);
        fork_idx    = 5'(n + 3);
        caller_ksu  = 2'(n);
        caller_asid = 8'h40 + 8'(n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(fork_ok == 0 && fork_fault == 0, "R1 pulses", {fork_ok, fork_fault}, 0);
        check(wr_ctx == 0, "R1 wr_ctx", wr_ctx, 0);
        check(exc_code == 0, "R1 exc_code", exc_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < NV; n++) begin
            load(VECS[n], n);
            fork_req = 1'b1;
            @(negedge clk);
            fork_req = 1'b0;
            check(wr_ctx == VECS[n].exp, "R2 R3 R4 target", wr_ctx, VECS[n].exp);
            if (VECS[n].exp != 0) begin
                check(fork_ok && !fork_fault, "R9 success pulse", {fork_ok, fork_fault}, 2);
                check(wr_pc == fork_pc && wr_gpr_val == fork_val && wr_gpr_idx == fork_idx,
                      "R5 write data", wr_gpr_val, fork_val);
                check(wr_runst == 0 && !wr_dslot && wr_dirty && wr_active,
                      "R6 status", {wr_runst, wr_dslot, wr_dirty, wr_active}, 3);
                check(wr_ksu == caller_ksu && wr_asid == caller_asid,
                      "R7 inherit", {wr_ksu, wr_asid}, {caller_ksu, caller_asid});
            end else begin
                check(fork_fault && !fork_ok, "R8 fault pulse", {fork_ok, fork_fault}, 1);
                check(exc_code == 3'd1, "R8 exc_code", exc_code, 1);
            end
            @(negedge clk);
            check(!fork_ok && !fork_fault && wr_ctx == 0, "R9 single pulse",
                  {fork_ok, fork_fault}, 0);
        end

        // R10: request held high across three edges
        load(VECS[0], 0);
        fork_req = 1'b1;
        @(negedge clk);
        check(fork_ok && wr_ctx == 8'h01, "R10 first accept", wr_ctx, 1);
        @(negedge clk);
        check(!fork_ok && !fork_fault && wr_ctx == 0, "R10 busy ignored",
              {fork_ok, fork_fault}, 0);
        @(negedge clk);
        check(fork_ok && wr_ctx == 8'h01, "R10 re-accept", wr_ctx, 1);
        fork_req = 1'b0;
        @(negedge clk);

        // R1: reset clears a pending result
        load(VECS[7], 7);
        fork_req = 1'b1;
        @(negedge clk);
        fork_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!fork_fault && exc_code == 0, "R1 reset clears", exc_code, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule